// File: doc/BRIEF.md
# Boundary-Scan Chain Integrity Checker

This block is a small JTAG master. It confirms that a board's boundary-scan chain is intact before any interconnect testing begins. It generates the test clock from the system clock and brings the chain into its test-reset state, either with the dedicated reset pin or with five TMS-high cycles. It then walks the TAP controllers through an instruction-register capture and shifts the whole chain of captured instruction bits out. Next it resets again, so that every device selects its identification register. It captures those registers and shifts out 32 bits per device.

Each bit that arrives on TDO is compared on the fly against the chain description, which is held in parameters. That description gives the device count, the instruction length of each device, the expected capture pattern and compare mask, and the expected identification code. When the run ends the block reports pass or fail. On a failure it also reports which phase failed first and the position of the device that failed. From these a test engineer can tell a broken TAP connection from a missing, wrong or swapped part.

Top module: `scan_chain_checker`

## Requirements
- R1: While `rst` is high, and afterwards until the first accepted `start`, `tck`, `done`, `pass` and `tdi` are 0 and `trst_n` is 1.
- R2: Each half period of `tck` lasts `tck_div`+1 system clocks, using the divider value latched at `start`. `tms` and `tdi` change only on the system clock edge where `tck` falls. `tdo` is sampled on the edge where `tck` rises.
- R3: With `use_trst`=1, `trst_n` is low for the first 5 TCK cycles of a run and `tms` is 0 during that time. With `use_trst`=0, `trst_n` stays high and `tms` is 1 for the first 5 TCK cycles.
- R4: A run lasts exactly 5 + 5 + IR_TOTAL + 5 + 4 + 32·N_DEV rising TCK edges, plus 2 more. The TMS values are: reset, then 0,1,1,0,0 into Shift-IR, then 0 on each IR shift except 1 on the last, then five 1s back to test-reset, then 0,1,0,0 into Shift-DR, then 0 on each ID shift except 1 on the last, then 1,0 into Run-Test/Idle.
- R5: Bits leave the chain from device 0 (nearest TDO) first, least significant bit first. In each device's captured instruction, bit 0 must be 1 and bit 1 must be 0.
- R6: Captured instruction bits 2 and above are compared with the device's expected capture value only where that device's mask bit is 1. Where the mask bit is 0 they have no effect on the result.
- R7: Each device's 32-bit identification value is compared with its expected code. Bit 0 is always expected to be 1.
- R8: `tdi` is 1 at every rising TCK edge of a run.
- R9: When `done` rises, `pass` is 1 only if no compared bit mismatched. Otherwise `fail_phase` is 0 if any instruction bit mismatched (instruction phase takes precedence) and 1 for an identification mismatch. `fail_device` gives the device of the first mismatching bit in shift order.
- R10: A `start` that arrives during a run is ignored. `done` is cleared when a run is accepted. `done`, `pass`, `fail_phase` and `fail_device` hold until the next accepted `start`.
- R11: A TDO line stuck at 0 is reported as an instruction-phase failure at device 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a chain check when idle |
| use_trst | input | 1 | 1: reset the chain with `trst_n`; 0: reset with five TMS-high cycles |
| tck_div | input | DIV_W | Half-period of TCK in system clocks, minus one |
| tdo | input | 1 | Serial data from the chain |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Serial data into the chain |
| trst_n | output | 1 | Active-low test reset |
| done | output | 1 | Run finished; results valid |
| pass | output | 1 | Chain matched its description |
| fail_phase | output | 1 | 0: instruction capture failed; 1: identification failed |
| fail_device | output | DEV_W | Position of the first failing device |

## Verification
The bench keeps the default chain of three devices, with instruction lengths 5, 4 and 8. Device boundaries therefore fall at odd bit positions within the 17-bit instruction stream. Device 0 compares only its two fixed bits, while devices 1 and 2 are fully masked in, so one build covers both the masked-out and the checked cases of R6. A behavioural TAP model of each device is scrambled into Pause-DR before every run, which makes both reset modes show up as a difference in results. Divider values 0 to 3 cover the tightest case, where TCK toggles every system clock, as well as slower rates.

// File: rtl/scck_pkg.sv
package scck_pkg;

    localparam int IDX_W = 16;
    localparam int ID_W  = 32;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_RESET,
        PH_TO_IR,
        PH_SHIFT_IR,
        PH_RERESET,
        PH_TO_DR,
        PH_SHIFT_DR,
        PH_EXIT,
        PH_DONE
    } seq_phase_e;

    typedef enum logic {
        CHK_IR = 1'b0,
        CHK_ID = 1'b1
    } chk_kind_e;

    typedef struct packed {
        logic             valid;
        chk_kind_e        kind;
        logic [IDX_W-1:0] idx;
        logic             tdo;
    } shift_sample_t;

    // TMS for navigation phases (shift phases are handled by the sequencer)
    function automatic logic nav_tms(seq_phase_e ph, logic [IDX_W-1:0] step,
                                     logic trst_mode);
        case (ph)
            PH_RESET:   return !trst_mode;
            PH_TO_IR:   return (step == 16'd1) || (step == 16'd2);
            PH_RERESET: return 1'b1;
            PH_TO_DR:   return step == 16'd1;
            PH_EXIT:    return step == 16'd0;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic seq_phase_e next_phase(seq_phase_e ph);
        case (ph)
            PH_RESET:    return PH_TO_IR;
            PH_TO_IR:    return PH_SHIFT_IR;
            PH_SHIFT_IR: return PH_RERESET;
            PH_RERESET:  return PH_TO_DR;
            PH_TO_DR:    return PH_SHIFT_DR;
            PH_SHIFT_DR: return PH_EXIT;
            PH_EXIT:     return PH_DONE;
            default:     return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/scck_tck_gen.sv
module scck_tck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tck,
    output logic             rise_now,
    output logic             fall_now
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap     = run && (cnt == div);
    assign rise_now = wrap && !tck;
    assign fall_now = wrap && tck;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            tck <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            tck <= ~tck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/scck_sequencer.sv
module scck_sequencer
    import scck_pkg::*;
#(
    parameter int IR_TOTAL = 17,
    parameter int DR_TOTAL = 96
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          trst_mode_in,
    input  logic          rise_now,
    input  logic          fall_now,
    input  logic          tdo,
    output logic          busy,
    output logic          done_pulse,
    output logic          tms,
    output logic          tdi,
    output logic          trst_n,
    output shift_sample_t smp
);
    localparam logic [IDX_W-1:0] IR_N = IDX_W'(IR_TOTAL);
    localparam logic [IDX_W-1:0] DR_N = IDX_W'(DR_TOTAL);

    seq_phase_e       phase;
    logic [IDX_W-1:0] step;
    logic [IDX_W-1:0] len;
    logic             trst_mode;
    logic             shifting;
    logic             last_step;
    logic             tms_now;

    always_comb begin
        case (phase)
            PH_RESET, PH_TO_IR, PH_RERESET: len = 16'd5;
            PH_SHIFT_IR:                    len = IR_N;
            PH_TO_DR:                       len = 16'd4;
            PH_SHIFT_DR:                    len = DR_N;
            PH_EXIT:                        len = 16'd2;
            default:                        len = 16'd1;
        endcase
    end

    assign busy      = (phase != PH_IDLE) && (phase != PH_DONE);
    assign shifting  = (phase == PH_SHIFT_IR) || (phase == PH_SHIFT_DR);
    assign last_step = (step == len - 16'd1);
    assign tms_now   = shifting ? last_step : nav_tms(phase, step, trst_mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            step       <= '0;
            trst_mode  <= 1'b0;
            tms        <= 1'b1;
            tdi        <= 1'b0;
            trst_n     <= 1'b1;
            done_pulse <= 1'b0;
            smp        <= '0;
        end else begin
            done_pulse <= 1'b0;
            smp.valid  <= 1'b0;
            if (!busy) begin
                if (start) begin
                    phase     <= PH_RESET;
                    step      <= '0;
                    trst_mode <= trst_mode_in;
                    tms       <= !trst_mode_in;
                    trst_n    <= !trst_mode_in;
                    tdi       <= 1'b1;
                end
            end else begin
                if (rise_now) begin
                    if (shifting) begin
                        smp <= '{valid: 1'b1,
                                 kind:  (phase == PH_SHIFT_DR) ? CHK_ID : CHK_IR,
                                 idx:   step,
                                 tdo:   tdo};
                    end
                    if (last_step) begin
                        step  <= '0;
                        phase <= next_phase(phase);
                        if (phase == PH_EXIT) done_pulse <= 1'b1;
                    end else begin
                        step <= step + 16'd1;
                    end
                end
                if (fall_now) begin
                    tms    <= tms_now;
                    trst_n <= !(trst_mode && (phase == PH_RESET));
                end
            end
        end
    end
endmodule

// File: rtl/scck_compare.sv
module scck_compare
    import scck_pkg::*;
#(
    parameter int                     N_DEV    = 3,
    parameter int                     DEV_W    = 2,
    parameter logic [N_DEV*8-1:0]     IR_LENS  = '0,
    parameter logic [N_DEV*16-1:0]    IR_CAPS  = '0,
    parameter logic [N_DEV*16-1:0]    IR_MASKS = '0,
    parameter logic [N_DEV*ID_W-1:0]  IDCODES  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  shift_sample_t    smp,
    output logic             failed,
    output chk_kind_e        fail_kind,
    output logic [DEV_W-1:0] fail_dev
);
    localparam logic [N_DEV-1:0][7:0]      LENS_A  = IR_LENS;
    localparam logic [N_DEV-1:0][15:0]     CAPS_A  = IR_CAPS;
    localparam logic [N_DEV-1:0][15:0]     MASKS_A = IR_MASKS;
    localparam logic [N_DEV-1:0][ID_W-1:0] IDS_A   = IDCODES;

    logic [DEV_W-1:0] ir_dev, id_dev, cur_dev;
    logic [3:0]       ir_bit;
    logic [4:0]       id_bit;
    logic             exp_bit, checked;

    // locate the device and bit offset of an instruction-stream position
    always_comb begin
        int off;
        off    = 0;
        ir_dev = '0;
        ir_bit = '0;
        for (int d = 0; d < N_DEV; d++) begin
            if (int'(smp.idx) >= off &&
                int'(smp.idx) < off + int'(LENS_A[DEV_W'(d)])) begin
                ir_dev = DEV_W'(d);
                ir_bit = 4'(int'(smp.idx) - off);
            end
            off = off + int'(LENS_A[DEV_W'(d)]);
        end
    end

    assign id_dev = DEV_W'(smp.idx >> 5);
    assign id_bit = smp.idx[4:0];

    always_comb begin
        if (smp.kind == CHK_IR) begin
            cur_dev = ir_dev;
            if (ir_bit == 4'd0) begin
                exp_bit = 1'b1;
                checked = 1'b1;
            end else if (ir_bit == 4'd1) begin
                exp_bit = 1'b0;
                checked = 1'b1;
            end else begin
                exp_bit = CAPS_A[ir_dev][ir_bit];
                checked = MASKS_A[ir_dev][ir_bit];
            end
        end else begin
            cur_dev = id_dev;
            exp_bit = (id_bit == 5'd0) ? 1'b1 : IDS_A[id_dev][id_bit];
            checked = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            failed    <= 1'b0;
            fail_kind <= CHK_IR;
            fail_dev  <= '0;
        end else if (smp.valid && !failed && checked && (smp.tdo != exp_bit)) begin
            failed    <= 1'b1;
            fail_kind <= smp.kind;
            fail_dev  <= cur_dev;
        end
    end
endmodule

// File: rtl/scan_chain_checker.sv
module scan_chain_checker
    import scck_pkg::*;
#(
    parameter int N_DEV = 3,
    parameter int DIV_W = 8,
    parameter logic [N_DEV*8-1:0]    IR_LENS  = {8'd8, 8'd4, 8'd5},
    parameter logic [N_DEV*16-1:0]   IR_CAPS  = {16'h0001, 16'h0005, 16'h0015},
    parameter logic [N_DEV*16-1:0]   IR_MASKS = {16'h00FF, 16'h000F, 16'h0003},
    parameter logic [N_DEV*ID_W-1:0] IDCODES  = {32'h2C90_11F3, 32'h4B7E_0065, 32'h0A1B_3C4D},
    localparam int DEV_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             use_trst,
    input  logic [DIV_W-1:0] tck_div,
    input  logic             tdo,
    output logic             tck,
    output logic             tms,
    output logic             tdi,
    output logic             trst_n,
    output logic             done,
    output logic             pass,
    output logic             fail_phase,
    output logic [DEV_W-1:0] fail_device
);
    localparam logic [N_DEV-1:0][7:0] LENS_A = IR_LENS;

    function automatic int sum_ir_len();
        int s = 0;
        for (int d = 0; d < N_DEV; d++) s = s + int'(LENS_A[DEV_W'(d)]);
        return s;
    endfunction

    localparam int IR_TOTAL = sum_ir_len();
    localparam int DR_TOTAL = N_DEV * ID_W;

    logic             busy, done_pulse, rise_now, fall_now, failed, accept;
    logic [DIV_W-1:0] div_q;
    shift_sample_t    smp;
    chk_kind_e        fail_kind;

    assign accept = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            done  <= 1'b0;
        end else begin
            if (accept) begin
                div_q <= tck_div;
                done  <= 1'b0;
            end else if (done_pulse) begin
                done <= 1'b1;
            end
        end
    end

    scck_tck_gen #(.DIV_W(DIV_W)) u_tck (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .div      (div_q),
        .tck      (tck),
        .rise_now (rise_now),
        .fall_now (fall_now)
    );

    scck_sequencer #(.IR_TOTAL(IR_TOTAL), .DR_TOTAL(DR_TOTAL)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .trst_mode_in (use_trst),
        .rise_now     (rise_now),
        .fall_now     (fall_now),
        .tdo          (tdo),
        .busy         (busy),
        .done_pulse   (done_pulse),
        .tms          (tms),
        .tdi          (tdi),
        .trst_n       (trst_n),
        .smp          (smp)
    );

    scck_compare #(
        .N_DEV    (N_DEV),
        .DEV_W    (DEV_W),
        .IR_LENS  (IR_LENS),
        .IR_CAPS  (IR_CAPS),
        .IR_MASKS (IR_MASKS),
        .IDCODES  (IDCODES)
    ) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .smp       (smp),
        .failed    (failed),
        .fail_kind (fail_kind),
        .fail_dev  (fail_device)
    );

    assign pass       = done && !failed;
    assign fail_phase = (fail_kind == CHK_ID);
endmodule

// File: rtl/scck_checker.sv
module scck_checker #(
    parameter int N_DEV = 3,
    parameter int DEV_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             tck,
    input logic             tms,
    input logic             tdi,
    input logic             trst_n,
    input logic             done,
    input logic             pass,
    input logic [DEV_W-1:0] fail_device
);
    assert_tms_steady_at_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(tck) |-> $stable(tms));

    assert_trst_with_tms_low_R3: assert property (@(posedge clk) disable iff (rst)
        !trst_n |-> !tms);

    assert_tdi_high_at_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(tck) |-> tdi);

    assert_pass_only_when_done_R9: assert property (@(posedge clk) disable iff (rst)
        pass |-> done);

    assert_fail_device_in_range_R9: assert property (@(posedge clk) disable iff (rst)
        (done && !pass) |-> (int'(fail_device) < N_DEV));

    assert_done_held_R10: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
endmodule

bind scan_chain_checker scck_checker #(.N_DEV(N_DEV), .DEV_W(DEV_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .tck         (tck),
    .tms         (tms),
    .tdi         (tdi),
    .trst_n      (trst_n),
    .done        (done),
    .pass        (pass),
    .fail_device (fail_device)
);

// File: tb/scan_chain_checker_bench.sv
`timescale 1ns/1ps

module scck_tap_model #(
    parameter int              IRL = 4,
    parameter logic [IRL-1:0]  CAP = '0,
    parameter logic [31:0]     IDV = 32'h1
) (
    input  logic           tck,
    input  logic           tms,
    input  logic           tdi,
    input  logic           trst_n,
    input  logic           scr,
    input  logic [IRL-1:0] cap_xor,
    input  logic [31:0]    id_xor,
    output logic           tdo
);
    typedef enum logic [3:0] {
        TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
    } tap_e;

    tap_e           st = TLR;
    logic [IRL-1:0] ir_sr = '0;
    logic [31:0]    dr = '0;
    logic           byp = 1'b0;
    logic           sel_id = 1'b1;

    initial tdo = 1'b1;

    function automatic tap_e nxt(tap_e s, logic m);
        case (s)
            TLR:    return m ? TLR    : RTI;
            RTI:    return m ? SEL_DR : RTI;
            SEL_DR: return m ? SEL_IR : CAP_DR;
            CAP_DR: return m ? EX1_DR : SH_DR;
            SH_DR:  return m ? EX1_DR : SH_DR;
            EX1_DR: return m ? UPD_DR : PAU_DR;
            PAU_DR: return m ? EX2_DR : PAU_DR;
            EX2_DR: return m ? UPD_DR : SH_DR;
            UPD_DR: return m ? SEL_DR : RTI;
            SEL_IR: return m ? TLR    : CAP_IR;
            CAP_IR: return m ? EX1_IR : SH_IR;
            SH_IR:  return m ? EX1_IR : SH_IR;
            EX1_IR: return m ? UPD_IR : PAU_IR;
            PAU_IR: return m ? EX2_IR : PAU_IR;
            EX2_IR: return m ? UPD_IR : SH_IR;
            default: return m ? SEL_DR : RTI;
        endcase
    endfunction

    always @(posedge tck or negedge trst_n or posedge scr) begin
        if (!trst_n) begin
            st     <= TLR;
            sel_id <= 1'b1;
        end else if (scr) begin
            st <= PAU_DR;
        end else begin
            case (st)
                TLR:    sel_id <= 1'b1;
                CAP_IR: ir_sr  <= CAP ^ cap_xor;
                SH_IR:  ir_sr  <= {tdi, ir_sr[IRL-1:1]};
                UPD_IR: sel_id <= (ir_sr == IRL'(1));
                CAP_DR: if (sel_id) dr <= IDV ^ id_xor; else byp <= 1'b0;
                SH_DR:  if (sel_id) dr <= {tdi, dr[31:1]}; else byp <= tdi;
                default: ;
            endcase
            st <= nxt(st, tms);
        end
    end

    always @(negedge tck) begin
        case (st)
            SH_IR:   tdo <= ir_sr[0];
            SH_DR:   tdo <= sel_id ? dr[0] : byp;
            default: tdo <= 1'b1;
        endcase
    end
endmodule

module scan_chain_checker_bench;

    localparam int RUN_RISES = 5 + 5 + 17 + 5 + 4 + 96 + 2;

    typedef struct packed {
        logic        trst;
        logic [7:0]  div;
        logic [15:0] cx0, cx1, cx2;
        logic [31:0] ix0, ix1, ix2;
        logic        stuck;
        logic        e_pass;
        logic        e_phase;
        logic [1:0]  e_dev;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // clean chain, TRST reset (R3, R5, R7)
        '{1'b1, 8'd1, 16'h0, 16'h0, 16'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0, 2'd0},
        // clean chain, TMS reset (R3)
        '{1'b0, 8'd2, 16'h0, 16'h0, 16'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0, 2'd0},
        // dev1 masked-in bit 3 flipped (R6)
        '{1'b0, 8'd0, 16'h0, 16'h8, 16'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'd1},
        // dev0 masked-out bit 4 flipped: ignored (R6)
        '{1'b1, 8'd1, 16'h10, 16'h0, 16'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0, 2'd0},
        // dev2 bit 0 of capture reads 0 (R5)
        '{1'b0, 8'd3, 16'h0, 16'h0, 16'h1, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'd2},
        // dev1 ID bit 12 wrong (R7)
        '{1'b0, 8'd1, 16'h0, 16'h0, 16'h0, 32'h0, 32'h1000, 32'h0, 1'b0, 1'b0, 1'b1, 2'd1},
        // ID errors on dev0 and dev2: first in shift order wins (R9)
        '{1'b1, 8'd0, 16'h0, 16'h0, 16'h0, 32'h8000_0000, 32'h0, 32'h1, 1'b0, 1'b0, 1'b1, 2'd0},
        // TDO stuck at 0 (R11)
        '{1'b0, 8'd1, 16'h0, 16'h0, 16'h0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 2'd0},
        // IR error dev2 plus ID error dev0: instruction phase wins (R9)
        '{1'b0, 8'd2, 16'h0, 16'h0, 16'h80, 32'h1, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'd2},
        // dev2 ID bit 0 reads 0 (R7)
        '{1'b1, 8'd1, 16'h0, 16'h0, 16'h0, 32'h0, 32'h0, 32'h1, 1'b0, 1'b0, 1'b1, 2'd2},
        // dev0 fixed bit 1 reads 1 despite mask (R5)
        '{1'b0, 8'd1, 16'h2, 16'h0, 16'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'd0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       use_trst = 1'b0;
    logic [7:0] tck_div = 8'd0;
    logic       tdo;
    logic       tck, tms, tdi, trst_n, done, pass, fail_phase;
    logic [1:0] fail_device;

    logic        scr = 1'b0;
    logic        stuck = 1'b0;
    logic [15:0] cx0 = '0, cx1 = '0, cx2 = '0;
    logic [31:0] ix0 = '0, ix1 = '0, ix2 = '0;
    logic        t21, t10, t0o;

    int  n_chk = 0, n_bad = 0;
    int  rises = 0, trst_rises = 0, tdi_bad = 0;
    time t_r1 = 0, t_r2 = 0;

    always #5 clk = ~clk;

    scan_chain_checker u_scan_chain_checker (
        .clk (clk), .rst (rst), .start (start), .use_trst (use_trst),
        .tck_div (tck_div), .tdo (tdo), .tck (tck), .tms (tms), .tdi (tdi),
        .trst_n (trst_n), .done (done), .pass (pass), .fail_phase (fail_phase),
        .fail_device (fail_device)
    );

    scck_tap_model #(.IRL(8), .CAP(8'h01), .IDV(32'h2C90_11F3)) u_dev2 (
        .tck (tck), .tms (tms), .tdi (tdi), .trst_n (trst_n), .scr (scr),
        .cap_xor (cx2[7:0]), .id_xor (ix2), .tdo (t21));
    scck_tap_model #(.IRL(4), .CAP(4'h5), .IDV(32'h4B7E_0065)) u_dev1 (
        .tck (tck), .tms (tms), .tdi (t21), .trst_n (trst_n), .scr (scr),
        .cap_xor (cx1[3:0]), .id_xor (ix1), .tdo (t10));
    scck_tap_model #(.IRL(5), .CAP(5'h15), .IDV(32'h0A1B_3C4D)) u_dev0 (
        .tck (tck), .tms (tms), .tdi (t10), .trst_n (trst_n), .scr (scr),
        .cap_xor (cx0[4:0]), .id_xor (ix0), .tdo (t0o));

    assign tdo = stuck ? 1'b0 : t0o;

    always @(posedge tck) begin
        rises = rises + 1;
        if (!trst_n) trst_rises = trst_rises + 1;
        if (!tdi) tdi_bad = tdi_bad + 1;
        if (rises == 1) t_r1 = $time;
        if (rises == 2) t_r2 = $time;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int c = 0; c < 5000; c++) begin
            @(negedge clk);
            if (done) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        #3_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_up();
    end

    initial begin
        bit ok;
        repeat (4) @(negedge clk);
        // R1: state during reset
        chk("R1 tck in reset", tck, 0);
        chk("R1 trst_n in reset", trst_n, 1);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 done after reset", done, 0);
        chk("R1 pass after reset", pass, 0);
        chk("R1 tdi after reset", tdi, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            cx0 = v.cx0; cx1 = v.cx1; cx2 = v.cx2;
            ix0 = v.ix0; ix1 = v.ix1; ix2 = v.ix2;
            stuck = v.stuck;
            use_trst = v.trst;
            tck_div = v.div;
            @(negedge clk); scr = 1'b1;
            @(negedge clk); scr = 1'b0;
            rises = 0; trst_rises = 0; tdi_bad = 0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R10 done cleared on start", done, 0);
            repeat (60) @(negedge clk);
            start = 1'b1;           // ignored mid-run (R10)
            tck_div = 8'd7;
            @(negedge clk);
            start = 1'b0;
            wait_done(ok);
            if (!ok) begin
                chk("watchdog run", 0, 1);
                finish_up();
            end
            chk("R4 rising edges per run", rises, RUN_RISES);
            chk("R3 trst low edges", trst_rises, v.trst ? 5 : 0);
            chk("R8 tdi low at rise", tdi_bad, 0);
            chk("R2 tck period ns", longint'(t_r2 - t_r1), 20 * (int'(v.div) + 1));
            chk("R9 pass", pass, v.e_pass);
            if (!v.e_pass) begin
                chk("R9 fail_phase", fail_phase, v.e_phase);
                chk("R9 fail_device", fail_device, v.e_dev);
            end
            repeat (20) @(negedge clk);
            chk("R10 done held", done, 1);
            chk("R10 pass held", pass, v.e_pass);
        end

        // R3/R4: without any chain reset a scrambled TAP cannot pass; confirm
        // that both reset modes recover from Pause-DR (already covered above)
        // and that the final result survives idle time.
        cx0 = '0; cx1 = '0; cx2 = '0; ix0 = '0; ix1 = '0; ix2 = '0; stuck = 1'b0;
        repeat (10) @(negedge clk);
        chk("R10 idle tck low", tck, 0);
        finish_up();
    end
endmodule